// File: doc/BRIEF.md
# Unaligned Load/Store Alignment Converter

This block sits between a core-side port that issues single 32-bit loads and stores at any byte address and a 64-bit memory port. The memory port only accepts addresses that are a whole multiple of the transfer size. The converter accepts one request at a time. It works out from the low address bits how many downstream beats the request needs and what size each beat has. It places write bytes and strobes on the correct lanes. For a load, it assembles the result from the lanes that hold the requested bytes.

Word-aligned requests go out as one 4-byte beat. A request that is misaligned but stays inside one 8-byte window is widened to one 8-byte beat at the window base. A request that straddles an 8-byte boundary becomes two 8-byte beats, lower window first. Requests marked as device memory are rejected with an error when they are not word-aligned, and nothing reaches the memory port for them.

On the downstream side, the block presents each beat with a valid/ready handshake and then waits for a separate response pulse before it continues. The core sees a request handshake, then one response pulse that carries an error flag and the load data.

Top module: `ualign_conv`

## Requirements
- R1: Every downstream beat address is a multiple of its transfer size. Size code 2 means 4 bytes and size code 3 means 8 bytes.
- R2: A request whose address bits [1:0] are 00 (byte offset 0 or 4 within the 8-byte window) is sent as exactly one beat. That beat has size code 2 and the request address unchanged.
- R3: A request with byte offset 1, 2 or 3 is sent as exactly one beat. That beat has size code 3 and the address with bits [2:0] cleared.
- R4: A request with byte offset 5, 6 or 7 is sent as two beats, both with size code 3. The first beat goes to the window base and the second to base+8, in that order.
- R5: On a store, request byte i goes out on lane (offset+i) mod 8 of the beat that covers address offset+i. Exactly those lanes have their strobe set.
- R6: On a load, result byte i is taken from lane (offset+i) mod 8 of the beat that covers that byte.
- R7: A device-memory request whose address bits [1:0] are not 00 completes with the error flag set and zero data. No downstream beat is issued for it.
- R8: If any downstream response carries an error, the request completes with the error flag set and zero data, and no later beat is issued. Store responses return zero data.
- R9: The request ready signal is low from the cycle after acceptance until the response pulse has ended. The response pulse lasts exactly one cycle per accepted request.
- R10: While a beat is valid and not accepted, its valid, address, size, data and strobes hold steady.
- R11: After reset, request ready is high and both the downstream valid and the response valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Converter idle and taking a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_device | input | 1 | Request targets device memory |
| req_addr | input | ADDR_W | Byte address, any alignment |
| req_wdata | input | 32 | Store data, byte 0 at the lowest address |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_err | output | 1 | Completion carries an error |
| resp_rdata | output | 32 | Load result, zero on error or store |
| mem_valid | output | 1 | Downstream beat present |
| mem_ready | input | 1 | Downstream beat taken |
| mem_write | output | 1 | Beat is a write |
| mem_addr | output | ADDR_W | Size-aligned beat address |
| mem_size | output | 3 | log2 of beat bytes (2 or 3) |
| mem_wdata | output | 64 | Write data on byte lanes |
| mem_wstrb | output | 8 | Byte-lane write enables |
| mem_rsp_valid | input | 1 | Downstream response pulse |
| mem_rsp_err | input | 1 | Downstream response error |
| mem_rsp_rdata | input | 64 | Read data on byte lanes |

## Verification
For a straddling request, the second-beat response can carry an error. That error and the merge of the two halves then fall in the same cycle, and the error must win: no data returns to the core, and for a store the first window keeps its write while the second stays untouched. The bench provokes this by arming the error slot on the upper window for offsets 5 to 7. It does this both directly and at random, and also arms the lower window to confirm that the second beat is never issued. Each completion is judged against a byte-level reference memory, together with the number, order and addresses of the beats the memory model recorded.

// File: rtl/ualign_pkg.sv
// Shared definitions for the alignment converter.
package ualign_pkg;
    // Sequencer states: idle, beat offered, beat awaiting response, completion pulse
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } ua_state_e;
endpackage

// File: rtl/ualign_plan.sv
// ualign_plan: decides how a word access maps onto the wide bus.
// Assumes WORD_BYTES and BUS_BYTES are powers of two with WORD_BYTES < BUS_BYTES.
// Purely combinational; outputs are valid whenever addr/device are.
module ualign_plan #(
    parameter int ADDR_W     = 32,
    parameter int BUS_BYTES  = 8,
    parameter int WORD_BYTES = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              device,
    output logic [ADDR_W-1:0] first_addr,
    output logic [ADDR_W-1:0] second_addr,
    output logic [2:0]        size,
    output logic              two_beats,
    output logic              reject
);
    localparam int OFF_W  = $clog2(BUS_BYTES);
    localparam int WOFF_W = $clog2(WORD_BYTES);

    logic [OFF_W-1:0]  off;
    logic              word_ok;
    logic [ADDR_W-1:0] base;

    // Classify the offset and derive beat addresses and size
    always_comb begin
        off         = addr[OFF_W-1:0];
        word_ok     = (addr[WOFF_W-1:0] == '0);
        base        = {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        two_beats   = ({1'b0, off} + (OFF_W+1)'(WORD_BYTES)) > (OFF_W+1)'(BUS_BYTES);
        reject      = device && !word_ok;
        size        = word_ok ? 3'(WOFF_W) : 3'(OFF_W);
        first_addr  = word_ok ? addr : base;
        second_addr = base + ADDR_W'(BUS_BYTES);
    end
endmodule

// File: rtl/ualign_lanes.sv
// ualign_lanes: byte-lane steering over a double-width window (two beats).
// Store side spreads the word across lanes and strobes; load side gathers
// result byte i from window position off+i. Assumes WORD_BYTES is a power of two.
module ualign_lanes #(
    parameter int BUS_BYTES  = 8,
    parameter int WORD_BYTES = 4
) (
    input  logic [$clog2(BUS_BYTES)-1:0] off,
    input  logic [WORD_BYTES*8-1:0]      wword,
    input  logic [BUS_BYTES*8-1:0]       rbeat_lo,
    input  logic [BUS_BYTES*8-1:0]       rbeat_hi,
    output logic [2*BUS_BYTES*8-1:0]     wide_data,
    output logic [2*BUS_BYTES-1:0]       wide_strb,
    output logic [WORD_BYTES*8-1:0]      rword
);
    localparam int OFF_W  = $clog2(BUS_BYTES);
    localparam int WOFF_W = $clog2(WORD_BYTES);
    localparam int LANES  = 2 * BUS_BYTES;

    logic [LANES*8-1:0] rwide;
    assign rwide = {rbeat_hi, rbeat_lo};

    // Store steering: each window lane picks its source byte and strobe
    for (genvar j = 0; j < LANES; j++) begin : g_wlane
        logic [OFF_W:0] rel;
        assign rel                = (OFF_W+1)'(j) - {1'b0, off};
        assign wide_strb[j]       = rel < (OFF_W+1)'(WORD_BYTES);
        assign wide_data[j*8 +: 8] = wword[rel[WOFF_W-1:0]*8 +: 8];
    end

    // Load gathering: each result byte reads its window position
    for (genvar i = 0; i < WORD_BYTES; i++) begin : g_rbyte
        logic [OFF_W:0] pos;
        assign pos              = {1'b0, off} + (OFF_W+1)'(i);
        assign rword[i*8 +: 8]  = rwide[pos*8 +: 8];
    end
endmodule

// File: rtl/ualign_conv.sv
// ualign_conv: converts word loads/stores at any byte address into
// size-aligned beats on a wide memory port. One request outstanding;
// each beat is handshaked, then its response pulse is awaited.
// Assumes the memory port answers each accepted beat with exactly one response.
module ualign_conv #(
    parameter int ADDR_W     = 32,
    parameter int BUS_BYTES  = 8,
    parameter int WORD_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic                    req_device,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [WORD_BYTES*8-1:0] req_wdata,
    output logic                    resp_valid,
    output logic                    resp_err,
    output logic [WORD_BYTES*8-1:0] resp_rdata,
    output logic                    mem_valid,
    input  logic                    mem_ready,
    output logic                    mem_write,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [2:0]              mem_size,
    output logic [BUS_BYTES*8-1:0]  mem_wdata,
    output logic [BUS_BYTES-1:0]    mem_wstrb,
    input  logic                    mem_rsp_valid,
    input  logic                    mem_rsp_err,
    input  logic [BUS_BYTES*8-1:0]  mem_rsp_rdata
);
    import ualign_pkg::*;

    localparam int OFF_W  = $clog2(BUS_BYTES);
    localparam int BUS_W  = BUS_BYTES * 8;
    localparam int WORD_W = WORD_BYTES * 8;

    ua_state_e         state;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] wdata_q;
    logic              write_q;
    logic              device_q;
    logic              beat_q;
    logic [BUS_W-1:0]  low_q;
    logic [WORD_W-1:0] rdata_q;
    logic              err_q;

    logic [ADDR_W-1:0]  plan_addr;
    logic               plan_dev;
    logic [ADDR_W-1:0]  first_addr, second_addr;
    logic [2:0]         size;
    logic               two_beats, reject;
    logic [2*BUS_W-1:0] wide_data;
    logic [2*BUS_BYTES-1:0] wide_strb;
    logic [BUS_W-1:0]   merge_lo;
    logic [WORD_W-1:0]  merged;
    logic               last_beat;

    // Plan on the incoming request while idle, on the held one otherwise
    assign plan_addr = (state == ST_IDLE) ? req_addr   : addr_q;
    assign plan_dev  = (state == ST_IDLE) ? req_device : device_q;

    ualign_plan #(
        .ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES), .WORD_BYTES(WORD_BYTES)
    ) u_plan (
        .addr(plan_addr), .device(plan_dev), .first_addr(first_addr),
        .second_addr(second_addr), .size(size), .two_beats(two_beats),
        .reject(reject)
    );

    // First-half data comes from the saved beat once the second is in flight
    assign merge_lo = beat_q ? low_q : mem_rsp_rdata;

    ualign_lanes #(
        .BUS_BYTES(BUS_BYTES), .WORD_BYTES(WORD_BYTES)
    ) u_lanes (
        .off(addr_q[OFF_W-1:0]), .wword(wdata_q), .rbeat_lo(merge_lo),
        .rbeat_hi(mem_rsp_rdata), .wide_data(wide_data),
        .wide_strb(wide_strb), .rword(merged)
    );

    assign last_beat = !two_beats || beat_q;

    // Request sequencer: accept, issue beats in order, complete
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            addr_q   <= '0;
            wdata_q  <= '0;
            write_q  <= 1'b0;
            device_q <= 1'b0;
            beat_q   <= 1'b0;
            low_q    <= '0;
            rdata_q  <= '0;
            err_q    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    addr_q   <= req_addr;
                    wdata_q  <= req_wdata;
                    write_q  <= req_write;
                    device_q <= req_device;
                    beat_q   <= 1'b0;
                    rdata_q  <= '0;
                    err_q    <= reject;
                    state    <= reject ? ST_DONE : ST_ISSUE;
                end
                ST_ISSUE: if (mem_ready) state <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid) begin
                    if (mem_rsp_err) begin
                        err_q   <= 1'b1;
                        rdata_q <= '0;
                        state   <= ST_DONE;
                    end else if (last_beat) begin
                        rdata_q <= write_q ? '0 : merged;
                        state   <= ST_DONE;
                    end else begin
                        low_q   <= mem_rsp_rdata;
                        beat_q  <= 1'b1;
                        state   <= ST_ISSUE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Port drive: beat fields select the window half by beat index
    always_comb begin
        req_ready  = (state == ST_IDLE);
        resp_valid = (state == ST_DONE);
        resp_err   = err_q;
        resp_rdata = rdata_q;
        mem_valid  = (state == ST_ISSUE);
        mem_write  = write_q;
        mem_addr   = beat_q ? second_addr : first_addr;
        mem_size   = size;
        mem_wdata  = beat_q ? wide_data[2*BUS_W-1:BUS_W] : wide_data[BUS_W-1:0];
        mem_wstrb  = write_q ? (beat_q ? wide_strb[2*BUS_BYTES-1:BUS_BYTES]
                                       : wide_strb[BUS_BYTES-1:0]) : '0;
    end
endmodule

// File: rtl/ualign_conv_chk.sv
// ualign_conv_chk: protocol and ordering properties of the converter ports.
// Tracks rejected device requests with one flag to check they stay off the bus.
module ualign_conv_chk #(
    parameter int ADDR_W     = 32,
    parameter int BUS_BYTES  = 8,
    parameter int WORD_BYTES = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   req_ready,
    input logic                   req_device,
    input logic [ADDR_W-1:0]      req_addr,
    input logic                   resp_valid,
    input logic                   mem_valid,
    input logic                   mem_ready,
    input logic [ADDR_W-1:0]      mem_addr,
    input logic [2:0]             mem_size,
    input logic [BUS_BYTES*8-1:0] mem_wdata,
    input logic [BUS_BYTES-1:0]   mem_wstrb,
    input logic                   mem_write
);
    localparam int WOFF_W = $clog2(WORD_BYTES);
    localparam int OFF_W  = $clog2(BUS_BYTES);

    logic rej_q;

    // Remember an accepted misaligned device request until it completes
    always_ff @(posedge clk) begin
        if (!rst_n)                 rej_q <= 1'b0;
        else if (resp_valid)        rej_q <= 1'b0;
        else if (req_valid && req_ready && req_device && req_addr[WOFF_W-1:0] != '0)
                                    rej_q <= 1'b1;
    end

    assert_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> ((mem_size == 3'(WOFF_W) && mem_addr[WOFF_W-1:0] == '0) ||
                       (mem_size == 3'(OFF_W)  && mem_addr[OFF_W-1:0]  == '0)));

    assert_word_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_write) |-> ($countones(mem_wstrb) >= 1 &&
                                      $countones(mem_wstrb) <= WORD_BYTES));

    assert_no_device_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rej_q |-> !mem_valid);

    assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    assert_busy_during_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !req_ready && !resp_valid);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
            $stable(mem_size) && $stable(mem_wdata) && $stable(mem_wstrb)));
endmodule

bind ualign_conv ualign_conv_chk #(
    .ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES), .WORD_BYTES(WORD_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_device(req_device), .req_addr(req_addr), .resp_valid(resp_valid),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb),
    .mem_write(mem_write)
);

// File: tb/tb_ualign_conv.sv
module tb_ualign_conv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_device = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_ready, resp_valid, resp_err;
    logic [31:0] resp_rdata;
    logic        mem_valid, mem_write;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_addr;
    logic [2:0]  mem_size;
    logic [63:0] mem_wdata;
    logic [7:0]  mem_wstrb;
    logic        mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
    logic [63:0] mem_rsp_rdata = '0;

    ualign_conv dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_device(req_device), .req_addr(req_addr),
        .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_err(resp_err),
        .resp_rdata(resp_rdata), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_write(mem_write), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_err(mem_rsp_err), .mem_rsp_rdata(mem_rsp_rdata)
    );

    always #4 clk = ~clk;

    int unsigned n_run = 0, n_fail = 0;
    logic [7:0]  mem_b [256];
    logic [7:0]  ref_b [256];
    bit          inject = 1'b0;
    logic [4:0]  err_slot = '0;
    int unsigned beat_cnt = 0;
    logic [31:0] beat_addr [2];
    logic [2:0]  beat_size [2];
    logic [31:0] s_addr;
    logic [63:0] s_data;
    logic [7:0]  s_strb;
    logic [2:0]  s_size;
    logic        s_write, s_err;
    logic [63:0] s_rd;
    bit          done_flag = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // Memory model: random ready and response latency, error slot, byte store
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mem_valid) begin
                s_addr = mem_addr; s_data = mem_wdata; s_strb = mem_wstrb;
                s_size = mem_size; s_write = mem_write;
                repeat ($urandom % 3) @(negedge clk);
                chk(mem_valid && mem_addr == s_addr && mem_wdata == s_data &&
                    mem_wstrb == s_strb && mem_size == s_size,
                    "R10 beat held", {32'd0, mem_addr}, {32'd0, s_addr});
                chk((s_size == 3'd2 && s_addr[1:0] == 2'b00) ||
                    (s_size == 3'd3 && s_addr[2:0] == 3'b000),
                    "R1 beat aligned", {29'd0, s_size}, {32'd0, s_addr});
                if (beat_cnt < 2) begin
                    beat_addr[beat_cnt] = s_addr;
                    beat_size[beat_cnt] = s_size;
                end
                beat_cnt++;
                mem_ready = 1'b1;
                @(negedge clk);
                mem_ready = 1'b0;
                repeat ($urandom % 3) @(negedge clk);
                s_err = inject && (s_addr[7:3] == err_slot);
                for (int j = 0; j < 8; j++) begin
                    if (s_write && !s_err && s_strb[j])
                        mem_b[{s_addr[7:3], 3'b000} + 8'(j)] = s_data[j*8 +: 8];
                    s_rd[j*8 +: 8] = mem_b[{s_addr[7:3], 3'b000} + 8'(j)];
                end
                mem_rsp_valid = 1'b1;
                mem_rsp_err   = s_err;
                mem_rsp_rdata = s_rd;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                mem_rsp_err   = 1'b0;
            end
        end
    end

    // One core request, checked against the byte reference model
    task automatic do_req(input logic [31:0] a, input logic [31:0] wd,
                          input bit wr, input bit dev, input bit inj,
                          input logic [4:0] slot);
        logic [2:0]  off = a[2:0];
        bit          aligned4 = (a[1:0] == 2'b00);
        bit          rej = dev && !aligned4;
        bit          two = (off > 3'd4);
        logic [31:0] base = {a[31:3], 3'b000};
        logic [31:0] upper = base + 32'd8;
        bit          err0, err1, exp_err;
        int unsigned exp_beats;
        logic [31:0] exp_rd = '0;
        string       btag;
        int unsigned wait_n = 0;
        inject = inj; err_slot = slot;
        err0 = !rej && inj && (base[7:3] == slot);
        err1 = !rej && two && !err0 && inj && (upper[7:3] == slot);
        exp_err   = rej || err0 || err1;
        exp_beats = rej ? 0 : (two ? (err0 ? 1 : 2) : 1);
        btag = rej ? "R7" : (aligned4 ? "R2" : (two ? "R4" : "R3"));
        if (!exp_err && !wr)
            for (int i = 0; i < 4; i++) exp_rd[i*8 +: 8] = ref_b[8'(a[7:0] + 8'(i))];
        beat_cnt = 0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_wdata = wd; req_write = wr; req_device = dev;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R9 busy after accept", {63'd0, req_ready}, 64'd0);
        while (!resp_valid && wait_n < 400) begin
            @(negedge clk);
            wait_n++;
        end
        chk(resp_valid, "R9 response seen", {63'd0, resp_valid}, 64'd1);
        chk(resp_err == exp_err, rej ? "R7 error flag" : "R8 error flag",
            {63'd0, resp_err}, {63'd0, exp_err});
        chk(resp_rdata == exp_rd, wr ? "R8 store data zero" : (exp_err ? "R8 data zero" : "R6 load merge"),
            {32'd0, resp_rdata}, {32'd0, exp_rd});
        chk(beat_cnt == exp_beats, {btag, " beat count"}, 64'(beat_cnt), 64'(exp_beats));
        if (exp_beats >= 1)
            chk(beat_addr[0] == (aligned4 ? a : base) && beat_size[0] == (aligned4 ? 3'd2 : 3'd3),
                {btag, " first beat"}, {29'd0, beat_size[0], beat_addr[0]}, {32'd0, aligned4 ? a : base});
        if (exp_beats == 2)
            chk(beat_addr[1] == upper && beat_size[1] == 3'd3, "R4 second beat",
                {29'd0, beat_size[1], beat_addr[1]}, {32'd0, upper});
        @(negedge clk);
        chk(!resp_valid && req_ready, "R9 single pulse", {62'd0, resp_valid, req_ready}, 64'd1);
        if (wr && !rej) begin
            for (int i = 0; i < 4; i++) begin
                bit hi = ({1'b0, off} + 4'(i)) >= 4'd8;
                if (hi ? !(err0 || err1) : !err0)
                    ref_b[8'(a[7:0] + 8'(i))] = wd[i*8 +: 8];
            end
            for (int k = -8; k < 16; k++) begin
                logic [7:0] ix = 8'(int'(a[7:0]) + k);
                chk(mem_b[ix] == ref_b[ix], "R5 store lanes", {56'd0, mem_b[ix]}, {56'd0, ref_b[ix]});
            end
        end
    endtask

    initial begin
        #(8 * 150000);
        chk(1'b0, "watchdog expired", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        int unsigned seed_set;
        seed_set = $urandom(32'd20240917);
        for (int i = 0; i < 256; i++) begin
            mem_b[i] = 8'(i * 7 + 3);
            ref_b[i] = 8'(i * 7 + 3);
        end
        repeat (4) @(negedge clk);
        chk(req_ready && !mem_valid && !resp_valid, "R11 reset state",
            {61'd0, req_ready, mem_valid, resp_valid}, 64'd4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !mem_valid && !resp_valid, "R11 after release",
            {61'd0, req_ready, mem_valid, resp_valid}, 64'd4);
        // Every offset, load then store then load (R2 R3 R4 R5 R6)
        for (int o = 0; o < 8; o++) begin
            do_req(32'h1000_0040 + 32'(o), 32'h0, 1'b0, 1'b0, 1'b0, 5'd0);
            do_req(32'h1000_0040 + 32'(o), 32'hA1B2_C3D4 + 32'(o), 1'b1, 1'b0, 1'b0, 5'd0);
            do_req(32'h1000_0040 + 32'(o), 32'h0, 1'b0, 1'b0, 1'b0, 5'd0);
        end
        // Device accesses: allowed at word offsets, refused otherwise (R7)
        do_req(32'h2000_0080, 32'h1111_2222, 1'b1, 1'b1, 1'b0, 5'd0);
        do_req(32'h2000_0084, 32'h0, 1'b0, 1'b1, 1'b0, 5'd0);
        do_req(32'h2000_0081, 32'h3333_4444, 1'b1, 1'b1, 1'b0, 5'd0);
        do_req(32'h2000_0086, 32'h0, 1'b0, 1'b1, 1'b0, 5'd0);
        // Errors on lower and upper half of straddling accesses (R8)
        do_req(32'h3000_00A6, 32'h0, 1'b0, 1'b0, 1'b1, 5'd20);
        do_req(32'h3000_00A6, 32'h0, 1'b0, 1'b0, 1'b1, 5'd21);
        do_req(32'h3000_00A7, 32'hDEAD_BEEF, 1'b1, 1'b0, 1'b1, 5'd21);
        do_req(32'h3000_00A5, 32'hCAFE_F00D, 1'b1, 1'b0, 1'b1, 5'd20);
        do_req(32'h3000_00A2, 32'h0, 1'b0, 1'b0, 1'b1, 5'd20);
        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [31:0] ra = $urandom;
            bit          rinj = ($urandom % 5) == 0;
            logic [31:0] rslot = {ra[31:3], 3'b000} + (($urandom % 2) == 1 ? 32'd8 : 32'd0);
            do_req(ra, $urandom, 1'($urandom % 2), ($urandom % 4) == 0, rinj, rslot[7:3]);
        end
        finish_run();
    end
endmodule